// File: doc/BRIEF.md
# Tagged Translation Buffer

This block is a small, fully associative translation buffer that sits in front of an in-memory page table. It holds recently used page-to-frame mappings. Each mapping is tagged with the address-space identifier of the process that owns it, so mappings from several processes can live side by side without being confused. A lookup presents a virtual page number, an identifier, a page offset and a read/write flag. One cycle later the block reports a hit or a miss. On a clean hit it also reports the frame number and the joined physical address. When a matching mapping forbids the access, it reports a protection fault or an invalid-page fault instead.

On a miss, an external walker fetches the mapping from the page table in memory, which costs an extra memory access. The walker then installs the mapping through the refill port. A refill goes to an empty slot when one exists; otherwise a round-robin pointer picks the slot to replace. Software invalidates entries with either a global flush or a flush that removes only one identifier's entries. Two entries that answer the same lookup are treated as an error: the lower-indexed entry supplies the result and a sticky flag is raised.

Top module: `tagged_xlate_buf`

## Requirements
- R1: After reset, `rsp_valid` and `multi_hit` are low and every slot is empty, so any lookup misses.
- R2: A lookup presented with `req_valid` high is answered exactly one clock later with `rsp_valid` high. `rsp_valid` is low in the cycle after a clock with no request.
- R3: A lookup hits only when an occupied slot matches both the page number and the identifier. Otherwise `rsp_miss` is 1 and `rsp_hit` is 0.
- R4: On a hit with no fault, `rsp_pfn` is the slot's frame number. `rsp_paddr` is that frame number in the upper bits with the request's page offset unchanged in the low `OFF_W` bits. On a miss or a fault, both outputs are zero.
- R5: A write that hits a present slot whose writable bit is 0 raises `rsp_fault_prot`. A read of the same slot completes normally.
- R6: A hit on a slot whose present bit is 0 raises `rsp_fault_inval` for reads and writes alike, and never `rsp_fault_prot`. Faults are raised only together with `rsp_hit`.
- R7: A refill writes the lowest-indexed empty slot. When all slots are occupied, it replaces the slot at a round-robin pointer. The pointer starts at 0 and advances by one, wrapping, after each replacement.
- R8: `flush_all` empties every slot at the next clock edge.
- R9: `flush_id_en` empties only the slots whose identifier equals `flush_id`. All other slots keep their mappings.
- R10: If several slots match a lookup, the lowest-indexed one supplies the result. `multi_hit` then goes high and stays high until reset, including across flushes.
- R11: A refill presented in the same cycle as either flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_id | input | ID_W | Address-space identifier of the requester |
| req_off | input | OFF_W | Page offset, passed through to the physical address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Registered response strobe |
| rsp_hit | output | 1 | A slot matched page and identifier |
| rsp_miss | output | 1 | No slot matched; a walk is needed |
| rsp_fault_prot | output | 1 | Write to a read-only page |
| rsp_fault_inval | output | 1 | Access to a page marked not present |
| rsp_pfn | output | PFN_W | Frame number on a clean hit, else 0 |
| rsp_paddr | output | PFN_W+OFF_W | Frame joined with offset on a clean hit, else 0 |
| multi_hit | output | 1 | Sticky duplicate-match error flag |
| fill_en | input | 1 | Install a mapping |
| fill_vpn | input | VPN_W | Page number of the new mapping |
| fill_id | input | ID_W | Identifier of the new mapping |
| fill_pfn | input | PFN_W | Frame number of the new mapping |
| fill_writable | input | 1 | 1 = read-write page, 0 = read-only |
| fill_present | input | 1 | 1 = page inside the address space, 0 = invalid page |
| flush_all | input | 1 | Empty every slot |
| flush_id_en | input | 1 | Empty the slots tagged with flush_id |
| flush_id | input | ID_W | Identifier to flush |

## Verification
The assertions take for granted that the request fields are stable only in the cycle in which `req_valid` is high. They also take for granted that the bench never counts on the content of a slot refilled while a flush is active. The protection-fault and offset checks compare a registered output against the previous cycle's request fields. The stimulus therefore changes request fields only at falling edges and holds each request for a single cycle. It also drives refills and flushes only in cycles in which no lookup result depends on them, except in the one scenario that targets the refill-versus-flush collision.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

    // Default geometry of the buffer.
    localparam int DEF_ENTRIES = 8;
    localparam int DEF_VPN_W   = 20;
    localparam int DEF_PFN_W   = 16;
    localparam int DEF_ID_W    = 8;
    localparam int DEF_OFF_W   = 12;

    // Outcome of one lookup.
    typedef enum logic [1:0] {
        RES_MISS  = 2'd0,
        RES_OK    = 2'd1,
        RES_PROT  = 2'd2,
        RES_INVAL = 2'd3
    } xres_e;

    // An invalid page outranks a permission problem.
    function automatic xres_e classify(input logic hit, input logic present,
                                       input logic writable, input logic is_write);
        xres_e r;
        if (!hit)                      r = RES_MISS;
        else if (!present)             r = RES_INVAL;
        else if (is_write && !writable) r = RES_PROT;
        else                           r = RES_OK;
        return r;
    endfunction

endpackage

// File: rtl/xlt_entry_store.sv
module xlt_entry_store #(
    parameter int N      = 8,
    parameter int VPN_W  = 20,
    parameter int PFN_W  = 16,
    parameter int ID_W   = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [VPN_W-1:0]          wr_vpn,
    input  logic [ID_W-1:0]           wr_id,
    input  logic [PFN_W-1:0]          wr_pfn,
    input  logic                      wr_writable,
    input  logic                      wr_present,
    input  logic                      clr_all,
    input  logic                      clr_id_en,
    input  logic [ID_W-1:0]           clr_id,
    input  logic [VPN_W-1:0]          lk_vpn,
    input  logic [ID_W-1:0]           lk_id,
    output logic [N-1:0]              match_vec,
    output logic [N-1:0]              occ_vec,
    output logic [N-1:0]              slot_writable,
    output logic [N-1:0]              slot_present,
    output logic [N-1:0][PFN_W-1:0]   slot_pfn
);

    typedef struct packed {
        logic             occ;
        logic [VPN_W-1:0] vpn;
        logic [ID_W-1:0]  id;
        logic [PFN_W-1:0] pfn;
        logic             writable;
        logic             present;
    } slot_t;

    for (genvar g = 0; g < N; g++) begin : g_slot
        slot_t ent_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else if (clr_all) begin
                ent_q.occ <= 1'b0;
            end else if (clr_id_en && ent_q.id == clr_id) begin
                ent_q.occ <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                ent_q.occ      <= 1'b1;
                ent_q.vpn      <= wr_vpn;
                ent_q.id       <= wr_id;
                ent_q.pfn      <= wr_pfn;
                ent_q.writable <= wr_writable;
                ent_q.present  <= wr_present;
            end
        end

        assign match_vec[g]     = ent_q.occ && (ent_q.vpn == lk_vpn) && (ent_q.id == lk_id);
        assign occ_vec[g]       = ent_q.occ;
        assign slot_writable[g] = ent_q.writable;
        assign slot_present[g]  = ent_q.present;
        assign slot_pfn[g]      = ent_q.pfn;
    end

endmodule

// File: rtl/xlt_hit_select.sv
module xlt_hit_select #(
    parameter int N      = 8,
    parameter int PFN_W  = 16,
    localparam int CNT_W = $clog2(N + 1)
) (
    input  logic [N-1:0]            match_vec,
    input  logic [N-1:0]            slot_writable,
    input  logic [N-1:0]            slot_present,
    input  logic [N-1:0][PFN_W-1:0] slot_pfn,
    output logic                    any_hit,
    output logic                    dup_hit,
    output logic [PFN_W-1:0]        sel_pfn,
    output logic                    sel_writable,
    output logic                    sel_present
);

    logic [CNT_W-1:0] n_match;

    always_comb begin
        sel_pfn      = '0;
        sel_writable = 1'b0;
        sel_present  = 1'b0;
        n_match      = '0;
        // Walk from the top so the lowest matching index is the one kept.
        for (int i = N - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                sel_pfn      = slot_pfn[i];
                sel_writable = slot_writable[i];
                sel_present  = slot_present[i];
                n_match      = n_match + 1'b1;
            end
        end
        any_hit = (n_match != '0);
        dup_hit = (n_match > CNT_W'(1));
    end

endmodule

// File: rtl/xlt_victim.sv
module xlt_victim #(
    parameter int N      = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     occ_vec,
    input  logic             alloc,
    output logic [IDX_W-1:0] victim_idx
);

    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] free_idx;
    logic             has_free;

    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!occ_vec[i]) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        victim_idx = has_free ? free_idx : rr_ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr <= '0;
        end else if (alloc && !has_free) begin
            rr_ptr <= (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/tagged_xlate_buf.sv
module tagged_xlate_buf
    import xlt_pkg::*;
#(
    parameter int ENTRIES = DEF_ENTRIES,
    parameter int VPN_W   = DEF_VPN_W,
    parameter int PFN_W   = DEF_PFN_W,
    parameter int ID_W    = DEF_ID_W,
    parameter int OFF_W   = DEF_OFF_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int PA_W   = PFN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [ID_W-1:0]  req_id,
    input  logic [OFF_W-1:0] req_off,
    input  logic             req_write,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault_prot,
    output logic             rsp_fault_inval,
    output logic [PFN_W-1:0] rsp_pfn,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             multi_hit,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [ID_W-1:0]  fill_id,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_writable,
    input  logic             fill_present,
    input  logic             flush_all,
    input  logic             flush_id_en,
    input  logic [ID_W-1:0]  flush_id
);

    logic [ENTRIES-1:0]            match_vec;
    logic [ENTRIES-1:0]            occ_vec;
    logic [ENTRIES-1:0]            slot_writable;
    logic [ENTRIES-1:0]            slot_present;
    logic [ENTRIES-1:0][PFN_W-1:0] slot_pfn;
    logic [IDX_W-1:0]              victim_idx;
    logic                          fill_ok;
    logic                          any_hit;
    logic                          dup_hit;
    logic [PFN_W-1:0]              sel_pfn;
    logic                          sel_writable;
    logic                          sel_present;
    xres_e                         res_d;

    // A flush in the same cycle drops the refill.
    assign fill_ok = fill_en && !flush_all && !flush_id_en;

    xlt_entry_store #(
        .N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ID_W(ID_W)
    ) store_i (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (fill_ok),
        .wr_idx       (victim_idx),
        .wr_vpn       (fill_vpn),
        .wr_id        (fill_id),
        .wr_pfn       (fill_pfn),
        .wr_writable  (fill_writable),
        .wr_present   (fill_present),
        .clr_all      (flush_all),
        .clr_id_en    (flush_id_en),
        .clr_id       (flush_id),
        .lk_vpn       (req_vpn),
        .lk_id        (req_id),
        .match_vec    (match_vec),
        .occ_vec      (occ_vec),
        .slot_writable(slot_writable),
        .slot_present (slot_present),
        .slot_pfn     (slot_pfn)
    );

    xlt_victim #(.N(ENTRIES)) victim_i (
        .clk       (clk),
        .rst       (rst),
        .occ_vec   (occ_vec),
        .alloc     (fill_ok),
        .victim_idx(victim_idx)
    );

    xlt_hit_select #(.N(ENTRIES), .PFN_W(PFN_W)) select_i (
        .match_vec    (match_vec),
        .slot_writable(slot_writable),
        .slot_present (slot_present),
        .slot_pfn     (slot_pfn),
        .any_hit      (any_hit),
        .dup_hit      (dup_hit),
        .sel_pfn      (sel_pfn),
        .sel_writable (sel_writable),
        .sel_present  (sel_present)
    );

    assign res_d = classify(any_hit, sel_present, sel_writable, req_write);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid       <= 1'b0;
            rsp_hit         <= 1'b0;
            rsp_miss        <= 1'b0;
            rsp_fault_prot  <= 1'b0;
            rsp_fault_inval <= 1'b0;
            rsp_pfn         <= '0;
            rsp_paddr       <= '0;
            multi_hit       <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_hit         <= any_hit;
                rsp_miss        <= !any_hit;
                rsp_fault_prot  <= (res_d == RES_PROT);
                rsp_fault_inval <= (res_d == RES_INVAL);
                rsp_pfn         <= (res_d == RES_OK) ? sel_pfn : '0;
                rsp_paddr       <= (res_d == RES_OK) ? {sel_pfn, req_off} : '0;
                if (dup_hit) multi_hit <= 1'b1;
            end else begin
                rsp_hit         <= 1'b0;
                rsp_miss        <= 1'b0;
                rsp_fault_prot  <= 1'b0;
                rsp_fault_inval <= 1'b0;
                rsp_pfn         <= '0;
                rsp_paddr       <= '0;
            end
        end
    end

endmodule

// File: rtl/tagged_xlate_buf_chk.sv
module tagged_xlate_buf_chk #(
    parameter int PFN_W  = 16,
    parameter int OFF_W  = 12,
    localparam int PA_W  = PFN_W + OFF_W
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [OFF_W-1:0] req_off,
    input logic             req_write,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_miss,
    input logic             rsp_fault_prot,
    input logic             rsp_fault_inval,
    input logic [PFN_W-1:0] rsp_pfn,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             multi_hit
);

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_hit_xor_miss_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss}) == 1));

    assert_fault_needs_hit_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_fault_prot || rsp_fault_inval) |-> rsp_hit);

    assert_one_fault_kind_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_fault_prot, rsp_fault_inval}));

    assert_prot_only_on_write_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_fault_prot |-> $past(req_write));

    assert_offset_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_hit && !rsp_fault_prot && !rsp_fault_inval) |->
            (rsp_paddr[OFF_W-1:0] == $past(req_off)) && (rsp_paddr[PA_W-1:OFF_W] == rsp_pfn));

    assert_multi_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        multi_hit |=> multi_hit);

endmodule

bind tagged_xlate_buf tagged_xlate_buf_chk #(.PFN_W(PFN_W), .OFF_W(OFF_W)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_off        (req_off),
    .req_write      (req_write),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_miss       (rsp_miss),
    .rsp_fault_prot (rsp_fault_prot),
    .rsp_fault_inval(rsp_fault_inval),
    .rsp_pfn        (rsp_pfn),
    .rsp_paddr      (rsp_paddr),
    .multi_hit      (multi_hit)
);

// File: tb/tagged_xlate_buf_tb_top.sv
module tagged_xlate_buf_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [19:0] req_vpn;
    logic [7:0]  req_id;
    logic [11:0] req_off;
    logic        req_write;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault_prot, rsp_fault_inval;
    logic [15:0] rsp_pfn;
    logic [27:0] rsp_paddr;
    logic        multi_hit;
    logic        fill_en;
    logic [19:0] fill_vpn;
    logic [7:0]  fill_id;
    logic [15:0] fill_pfn;
    logic        fill_writable, fill_present;
    logic        flush_all, flush_id_en;
    logic [7:0]  flush_id;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // Captured result of the last lookup.
    logic        r_valid, r_hit, r_miss, r_prot, r_inval;
    logic [15:0] r_pfn;
    logic [27:0] r_paddr;

    always #5 clk = ~clk;

    tagged_xlate_buf dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_vpn(req_vpn), .req_id(req_id),
        .req_off(req_off), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault_prot(rsp_fault_prot), .rsp_fault_inval(rsp_fault_inval),
        .rsp_pfn(rsp_pfn), .rsp_paddr(rsp_paddr), .multi_hit(multi_hit),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_id(fill_id),
        .fill_pfn(fill_pfn), .fill_writable(fill_writable), .fill_present(fill_present),
        .flush_all(flush_all), .flush_id_en(flush_id_en), .flush_id(flush_id)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_fill(input logic [19:0] vpn, input logic [7:0] id,
                           input logic [15:0] pfn, input logic wr, input logic pr);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn; fill_id = id; fill_pfn = pfn;
        fill_writable = wr; fill_present = pr;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic do_lookup(input logic [19:0] vpn, input logic [7:0] id,
                             input logic [11:0] off, input logic wr);
        @(negedge clk);
        req_valid = 1'b1; req_vpn = vpn; req_id = id; req_off = off; req_write = wr;
        @(negedge clk);
        r_valid = rsp_valid; r_hit = rsp_hit; r_miss = rsp_miss;
        r_prot = rsp_fault_prot; r_inval = rsp_fault_inval;
        r_pfn = rsp_pfn; r_paddr = rsp_paddr;
        req_valid = 1'b0;
    endtask

    task automatic do_flush_all();
        @(negedge clk);
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
    endtask

    task automatic do_flush_id(input logic [7:0] id);
        @(negedge clk);
        flush_id_en = 1'b1; flush_id = id;
        @(negedge clk);
        flush_id_en = 1'b0;
    endtask

    // R1 and R2: reset state and response timing.
    task automatic t_reset_and_timing();
        check("R1", "rsp_valid after reset", rsp_valid, 0);
        check("R1", "multi_hit after reset", multi_hit, 0);
        do_lookup(20'h0, 8'h0, 12'h0, 1'b0);
        check("R1", "empty buffer misses", r_miss, 1);
        check("R2", "rsp_valid one cycle after request", r_valid, 1);
        @(negedge clk);
        check("R2", "rsp_valid low after idle cycle", rsp_valid, 0);
    endtask

    // R3 and R4: tag match and address formation.
    task automatic t_basic_hit();
        do_fill(20'h12345, 8'h05, 16'hABCD, 1'b1, 1'b1);
        do_lookup(20'h12345, 8'h05, 12'h123, 1'b0);
        check("R3", "matching page and id hits", r_hit, 1);
        check("R4", "frame on hit", r_pfn, 16'hABCD);
        check("R4", "paddr on hit", r_paddr, 28'hABCD123);
        do_lookup(20'h12345, 8'h06, 12'h123, 1'b0);
        check("R3", "other id misses", r_miss, 1);
        check("R4", "paddr zero on miss", r_paddr, 0);
        do_lookup(20'h12346, 8'h05, 12'h000, 1'b1);
        check("R3", "other page misses", r_miss, 1);
    endtask

    // R5: read-only page.
    task automatic t_protection();
        do_fill(20'h00200, 8'h05, 16'h0042, 1'b0, 1'b1);
        do_lookup(20'h00200, 8'h05, 12'hFFF, 1'b0);
        check("R5", "read of read-only page no fault", r_prot, 0);
        check("R5", "read of read-only page paddr", r_paddr, 28'h0042FFF);
        do_lookup(20'h00200, 8'h05, 12'hFFF, 1'b1);
        check("R5", "write of read-only page faults", r_prot, 1);
        check("R5", "faulting write still hits", r_hit, 1);
        check("R5", "faulting write paddr zero", r_paddr, 0);
    endtask

    // R6: page marked not present.
    task automatic t_invalid_page();
        do_fill(20'h00300, 8'h05, 16'h0077, 1'b0, 1'b0);
        do_lookup(20'h00300, 8'h05, 12'h010, 1'b0);
        check("R6", "read of invalid page", r_inval, 1);
        check("R6", "read of invalid page pfn", r_pfn, 0);
        do_lookup(20'h00300, 8'h05, 12'h010, 1'b1);
        check("R6", "write of invalid page", r_inval, 1);
        check("R6", "invalid outranks protection", r_prot, 0);
    endtask

    // R9: flush by identifier.
    task automatic t_flush_id();
        do_fill(20'h00400, 8'h09, 16'h0099, 1'b1, 1'b1);
        do_flush_id(8'h05);
        do_lookup(20'h12345, 8'h05, 12'h0, 1'b0);
        check("R9", "flushed id misses", r_miss, 1);
        do_lookup(20'h00400, 8'h09, 12'h0, 1'b0);
        check("R9", "other id kept", r_hit, 1);
        check("R9", "other id frame", r_pfn, 16'h0099);
    endtask

    // R8 and R11: global flush and refill collision.
    task automatic t_flush_all();
        do_flush_all();
        do_lookup(20'h00400, 8'h09, 12'h0, 1'b0);
        check("R8", "global flush empties", r_miss, 1);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = 20'h00500; fill_id = 8'h01; fill_pfn = 16'h0555;
        fill_writable = 1'b1; fill_present = 1'b1; flush_all = 1'b1;
        @(negedge clk);
        fill_en = 1'b0; flush_all = 1'b0;
        do_lookup(20'h00500, 8'h01, 12'h0, 1'b0);
        check("R11", "refill with global flush dropped", r_miss, 1);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = 20'h00600; fill_id = 8'h01; fill_pfn = 16'h0666;
        flush_id_en = 1'b1; flush_id = 8'h02;
        @(negedge clk);
        fill_en = 1'b0; flush_id_en = 1'b0;
        do_lookup(20'h00600, 8'h01, 12'h0, 1'b0);
        check("R11", "refill with id flush dropped", r_miss, 1);
    endtask

    // R7: empty slots first, then round-robin from slot 0.
    task automatic t_replacement();
        for (int i = 0; i < 8; i++)
            do_fill(20'h01000 + 20'(i), 8'h01, 16'h0100 + 16'(i), 1'b1, 1'b1);
        for (int i = 0; i < 8; i++) begin
            do_lookup(20'h01000 + 20'(i), 8'h01, 12'h0, 1'b0);
            check("R7", "all eight fills resident", r_pfn, 16'h0100 + 16'(i));
        end
        do_fill(20'h02000, 8'h01, 16'h0200, 1'b1, 1'b1);
        do_lookup(20'h01000, 8'h01, 12'h0, 1'b0);
        check("R7", "slot 0 replaced first", r_miss, 1);
        do_lookup(20'h01001, 8'h01, 12'h0, 1'b0);
        check("R7", "slot 1 kept after first replace", r_hit, 1);
        do_lookup(20'h02000, 8'h01, 12'h0, 1'b0);
        check("R7", "new mapping resident", r_pfn, 16'h0200);
        do_fill(20'h02001, 8'h01, 16'h0201, 1'b1, 1'b1);
        do_lookup(20'h01001, 8'h01, 12'h0, 1'b0);
        check("R7", "slot 1 replaced second", r_miss, 1);
        do_lookup(20'h01002, 8'h01, 12'h0, 1'b0);
        check("R7", "slot 2 kept", r_hit, 1);
    endtask

    // R10: duplicate matches.
    task automatic t_multi_hit();
        do_flush_all();
        do_fill(20'h05000, 8'h03, 16'h0111, 1'b1, 1'b1);
        do_fill(20'h05000, 8'h03, 16'h0222, 1'b1, 1'b1);
        @(negedge clk);
        check("R10", "multi_hit low before duplicate lookup", multi_hit, 0);
        do_lookup(20'h05000, 8'h03, 12'h0, 1'b0);
        check("R10", "lowest slot supplies frame", r_pfn, 16'h0111);
        check("R10", "multi_hit raised", multi_hit, 1);
        do_fill(20'h06000, 8'h03, 16'h0333, 1'b1, 1'b1);
        do_lookup(20'h06000, 8'h03, 12'h0, 1'b0);
        check("R10", "multi_hit sticky after single hit", multi_hit, 1);
        do_flush_all();
        @(negedge clk);
        check("R10", "multi_hit sticky across flush", multi_hit, 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_vpn = '0; req_id = '0; req_off = '0;
        req_write = 1'b0; fill_en = 1'b0; fill_vpn = '0; fill_id = '0; fill_pfn = '0;
        fill_writable = 1'b0; fill_present = 1'b0; flush_all = 1'b0;
        flush_id_en = 1'b0; flush_id = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_and_timing();
        t_basic_hit();
        t_protection();
        t_invalid_page();
        t_flush_id();
        t_flush_all();
        t_replacement();
        t_multi_hit();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule